// File: doc/BRIEF.md
# I2C Master START Condition Sequencer

This block produces the START condition on a two-wire bus when it acts as bus master. Software writes a five-bit command word. Bit 0 of that word is the start request. When a request arrives and both bus lines read high, a countdown timer is loaded from a 7-bit reload value. After one timer period, SDA is pulled low while SCL stays high. This edge is the START condition, and a start-detected flag is raised. The timer is then loaded again. When the second period expires, the block clears the request bit, keeps SDA low and raises a completion flag.

Both lines are open-drain. The block only ever pulls SDA low through an output enable. Each line is read back through a two-stage synchronizer. A line found low when it should be high is a bus collision. In that case the sequence aborts, SDA is released, the block returns to idle and a collision flag is set. While a sequence is running, writes to the transmit buffer are refused and flagged, and command writes are dropped, so no further operation can be queued. Every status flag stays set until software clears it through a per-flag clear strobe.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset, SDA is released, busy is low, the command and buffer registers read 0, and all four flags read 0.
- R2: A command write with bit 0 set, made while not busy and with both synchronized lines high, starts the timer. SDA stays released for exactly reload+1 cycles. On the clock edge that ends this period, if both synchronized lines are still high, SDA is driven low and start_det_o (flag clear bit 0) is set on that same edge.
- R3: Once SDA is driven low, a second period of reload+1 cycles runs. At its end, cmd_o bit 0 is cleared, done_irq_o (flag clear bit 1) is set, busy drops and SDA stays driven low.
- R4: Each bus line passes through two synchronizer stages. A change on a pin affects the sequencer on the third rising clock edge after the change.
- R5: A start request is treated as a bus collision when either synchronized line is low. This includes SDA held low by the block itself after a completed start. A collision sets bus_coll_o (flag clear bit 2), leaves cmd_o bit 0 at 0, releases SDA and leaves the block idle.
- R6: During the first period, SCL low on any cycle, or SDA low at the timeout, aborts the sequence. The abort sets bus_coll_o, clears cmd_o bit 0, releases SDA and drops busy on the next edge.
- R7: SCL going low during the second period has no effect: there is no collision, and completion happens on time.
- R8: A buffer write while busy sets wr_coll_o (flag clear bit 3) and leaves buf_o unchanged. A buffer write while not busy loads buf_o on the next edge.
- R9: Command writes while busy are ignored: cmd_o bits 4..1 do not change.
- R10: Each flag stays set until its flag_clr_i bit is pulsed. If a set event and a clear occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_i | input | 5 | Command word; bit 0 requests a START |
| reload_i | input | 7 | Timer reload value; one period is reload+1 cycles |
| buf_wr_i | input | 1 | Transmit buffer write strobe |
| buf_data_i | input | 8 | Transmit buffer write data |
| flag_clr_i | input | 4 | Per-flag clear: 0 start, 1 done, 2 bus collision, 3 write collision |
| sda_i | input | 1 | SDA line level, asynchronous |
| scl_i | input | 1 | SCL line level, asynchronous |
| sda_oe_o | output | 1 | Pulls SDA low when high |
| busy_o | output | 1 | START sequence in progress |
| cmd_o | output | 5 | Command register contents |
| buf_o | output | 8 | Transmit buffer contents |
| start_det_o | output | 1 | START condition driven |
| done_irq_o | output | 1 | START sequence completed |
| bus_coll_o | output | 1 | Bus collision detected |
| wr_coll_o | output | 1 | Buffer write refused while busy |

## Verification
Two situations are hard to reach: a collision that occurs in the middle of the first period, and an SDA that drops just before the first timeout. Each needs the external line to move on a chosen cycle measured from the request. The bench makes the bus a wired-AND of its own line drivers and the block's SDA enable. It schedules line changes relative to the request edge, using a reload value large enough to leave room, and checks the two-cycle synchronizer lag exactly. A final request made while the block still holds SDA low covers the case where the block collides with itself.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_PARKED
  } seq_state_e;

  localparam int FLAG_N = 4;
  localparam int F_SDET = 0;
  localparam int F_DONE = 1;
  localparam int F_BCOL = 2;
  localparam int F_WCOL = 3;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = pipe_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[g] <= '1;
      else         pipe_q[g] <= src;
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2cs_baud.sv
module i2cs_baud #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          halt_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign tick_o = run_q && (cnt_q == '0);

  // load beats halt/timeout so a phase can chain straight into the next
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= 1'b1;
    end else if (halt_i || tick_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
  import i2cs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic sda_s_i,
  input  logic scl_s_i,
  input  logic tick_i,
  output logic tmr_load_o,
  output logic tmr_halt_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic sen_clr_o,
  output logic set_sdet_o,
  output logic set_done_o,
  output logic set_bcol_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_halt_o = 1'b0;
    sen_clr_o  = 1'b0;
    set_sdet_o = 1'b0;
    set_done_o = 1'b0;
    set_bcol_o = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_PARKED: begin
        if (go_i) begin
          if (sda_s_i && scl_s_i) begin
            state_d    = ST_LEAD;
            tmr_load_o = 1'b1;
          end else begin
            state_d    = ST_IDLE;
            set_bcol_o = 1'b1;
            sen_clr_o  = 1'b1;
          end
        end
      end
      ST_LEAD: begin
        if (!scl_s_i || (tick_i && !sda_s_i)) begin
          state_d    = ST_IDLE;
          tmr_halt_o = 1'b1;
          set_bcol_o = 1'b1;
          sen_clr_o  = 1'b1;
        end else if (tick_i) begin
          state_d    = ST_LOW;
          tmr_load_o = 1'b1;
          set_sdet_o = 1'b1;
        end
      end
      ST_LOW: begin
        if (tick_i) begin
          state_d    = ST_PARKED;
          sen_clr_o  = 1'b1;
          set_done_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign sda_oe_o = (state_q == ST_LOW) || (state_q == ST_PARKED);
  assign busy_o   = (state_q == ST_LEAD) || (state_q == ST_LOW);
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
#(
  parameter int CMD_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              cmd_wr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              sen_clr_i,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_data_i,
  input  logic [FLAG_N-1:0] seq_set_i,
  input  logic [FLAG_N-1:0] flag_clr_i,
  output logic              go_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [DATA_W-1:0] buf_o,
  output logic [FLAG_N-1:0] flags_o
);
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] buf_q;
  logic [FLAG_N-1:0] flags_q;
  logic [FLAG_N-1:0] set_all;
  logic              wr_open;

  assign wr_open = !busy_i;
  assign go_o    = cmd_wr_i && cmd_i[0] && wr_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (cmd_wr_i && wr_open) begin
      cmd_q <= {cmd_i[CMD_W-1:1], cmd_i[0] & ~sen_clr_i};
    end else if (sen_clr_i) begin
      cmd_q[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 buf_q <= '0;
    else if (buf_wr_i && wr_open) buf_q <= buf_data_i;
  end

  always_comb begin
    set_all         = seq_set_i;
    set_all[F_WCOL] = seq_set_i[F_WCOL] | (buf_wr_i & busy_i);
  end

  for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[f] <= 1'b0;
      else         flags_q[f] <= set_all[f] | (flags_q[f] & ~flag_clr_i[f]);
    end
  end

  assign cmd_o   = cmd_q;
  assign buf_o   = buf_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2cs_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int CMD_W       = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_wr_i,
  input  logic [CMD_W-1:0]    cmd_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                buf_wr_i,
  input  logic [DATA_W-1:0]   buf_data_i,
  input  logic [FLAG_N-1:0]   flag_clr_i,
  input  logic                sda_i,
  input  logic                scl_i,
  output logic                sda_oe_o,
  output logic                busy_o,
  output logic [CMD_W-1:0]    cmd_o,
  output logic [DATA_W-1:0]   buf_o,
  output logic                start_det_o,
  output logic                done_irq_o,
  output logic                bus_coll_o,
  output logic                wr_coll_o
);
  localparam int LINES = 2;

  logic [LINES-1:0]  line_s;
  logic              sda_s, scl_s;
  logic              go, tick, tmr_load, tmr_halt, sen_clr;
  logic              set_sdet, set_done, set_bcol;
  logic [FLAG_N-1:0] seq_set, flags;

  i2cs_sync #(.W(LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign sda_s = line_s[0];
  assign scl_s = line_s[1];

  i2cs_baud #(.CW(RELOAD_W)) i_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(reload_i),
    .halt_i    (tmr_halt),
    .tick_o    (tick)
  );

  i2cs_seq i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .sda_s_i   (sda_s),
    .scl_s_i   (scl_s),
    .tick_i    (tick),
    .tmr_load_o(tmr_load),
    .tmr_halt_o(tmr_halt),
    .sda_oe_o  (sda_oe_o),
    .busy_o    (busy_o),
    .sen_clr_o (sen_clr),
    .set_sdet_o(set_sdet),
    .set_done_o(set_done),
    .set_bcol_o(set_bcol)
  );

  always_comb begin
    seq_set         = '0;
    seq_set[F_SDET] = set_sdet;
    seq_set[F_DONE] = set_done;
    seq_set[F_BCOL] = set_bcol;
  end

  i2cs_regs #(.CMD_W(CMD_W), .DATA_W(DATA_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy_o),
    .cmd_wr_i  (cmd_wr_i),
    .cmd_i     (cmd_i),
    .sen_clr_i (sen_clr),
    .buf_wr_i  (buf_wr_i),
    .buf_data_i(buf_data_i),
    .seq_set_i (seq_set),
    .flag_clr_i(flag_clr_i),
    .go_o      (go),
    .cmd_o     (cmd_o),
    .buf_o     (buf_o),
    .flags_o   (flags)
  );

  assign start_det_o = flags[F_SDET];
  assign done_irq_o  = flags[F_DONE];
  assign bus_coll_o  = flags[F_BCOL];
  assign wr_coll_o   = flags[F_WCOL];
endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk #(
  parameter int CMD_W  = 5,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_wr_i,
  input logic              buf_wr_i,
  input logic [3:0]        flag_clr_i,
  input logic              scl_s_i,
  input logic              sda_oe_o,
  input logic              busy_o,
  input logic [CMD_W-1:0]  cmd_o,
  input logic [DATA_W-1:0] buf_o,
  input logic              start_det_o,
  input logic              done_irq_o,
  input logic              bus_coll_o,
  input logic              wr_coll_o
);
  AST_SDET_ON_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> start_det_o && busy_o);  // R2

  AST_DONE_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_irq_o) |-> !cmd_o[0] && !busy_o && sda_oe_o);  // R3

  AST_COLL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_coll_o) |-> !sda_oe_o && !busy_o && !cmd_o[0]);  // R5

  AST_SCL_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !sda_oe_o && !scl_s_i |=> !busy_o && bus_coll_o && !sda_oe_o);  // R6

  AST_LATE_SCL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && sda_oe_o && !bus_coll_o |=> !bus_coll_o);  // R7

  AST_BUF_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && buf_wr_i |=> $stable(buf_o) && wr_coll_o);  // R8

  AST_CMD_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cmd_wr_i |=> $stable(cmd_o[CMD_W-1:1]));  // R9

  AST_BCOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_coll_o && !flag_clr_i[2] |=> bus_coll_o);  // R10
endmodule

bind i2c_start_gen i2c_start_gen_chk #(.CMD_W(CMD_W), .DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_wr_i   (cmd_wr_i),
  .buf_wr_i   (buf_wr_i),
  .flag_clr_i (flag_clr_i),
  .scl_s_i    (scl_s),
  .sda_oe_o   (sda_oe_o),
  .busy_o     (busy_o),
  .cmd_o      (cmd_o),
  .buf_o      (buf_o),
  .start_det_o(start_det_o),
  .done_irq_o (done_irq_o),
  .bus_coll_o (bus_coll_o),
  .wr_coll_o  (wr_coll_o)
);

// File: tb/test_i2c_start_gen.sv
module test_i2c_start_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [4:0] cmd = '0;
  logic [6:0] rel = '0;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_data = '0;
  logic [3:0] fclr = '0;
  logic       ext_sda = 1'b1, ext_scl = 1'b1;
  logic       sda_line, scl_line;
  logic       sda_oe, busy, sdet, done, bcol, wcol;
  logic [4:0] cmd_q;
  logic [7:0] buf_q;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = ext_sda & ~sda_oe;
  assign scl_line = ext_scl;

  i2c_start_gen i_i2c_start_gen (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_i(cmd), .reload_i(rel),
    .buf_wr_i(buf_wr), .buf_data_i(buf_data), .flag_clr_i(fclr),
    .sda_i(sda_line), .scl_i(scl_line), .sda_oe_o(sda_oe), .busy_o(busy),
    .cmd_o(cmd_q), .buf_o(buf_q), .start_det_o(sdet), .done_irq_o(done),
    .bus_coll_o(bcol), .wr_coll_o(wcol)
  );

  // behavioural reference: phase 0 idle, 1 first period, 2 SDA low, 3 parked
  int       m_ph, m_cnt;
  bit       m_oe;
  bit [4:0] m_cmd;
  bit [7:0] m_buf;
  bit [3:0] m_fl;
  bit [1:0] m_sda_sh, m_scl_sh;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_oe = 0; m_cmd = 0; m_buf = 0; m_fl = 0;
      m_sda_sh = 2'b11; m_scl_sh = 2'b11;
    end else begin
      bit s_sda, s_scl, busy_now, expired, go, clr_en;
      bit [3:0] setv;
      s_sda = m_sda_sh[1];
      s_scl = m_scl_sh[1];
      busy_now = (m_ph == 1) || (m_ph == 2);
      expired = busy_now && (m_cnt == 0);
      go = cmd_wr && cmd[0] && !busy_now;
      clr_en = 0;
      setv = 0;
      if (busy_now && !expired) m_cnt = m_cnt - 1;
      case (m_ph)
        1: begin
          if (!s_scl || (expired && !s_sda)) begin
            setv[2] = 1; clr_en = 1; m_ph = 0;
          end else if (expired) begin
            setv[0] = 1; m_ph = 2; m_oe = 1; m_cnt = rel;
          end
        end
        2: if (expired) begin
          setv[1] = 1; clr_en = 1; m_ph = 3;
        end
        default: if (go) begin
          if (s_sda && s_scl) begin m_ph = 1; m_oe = 0; m_cnt = rel; end
          else begin setv[2] = 1; clr_en = 1; m_ph = 0; m_oe = 0; end
        end
      endcase
      if (cmd_wr && !busy_now) m_cmd = cmd;
      if (clr_en) m_cmd[0] = 0;
      if (buf_wr) begin
        if (busy_now) setv[3] = 1;
        else m_buf = buf_data;
      end
      m_fl = setv | (m_fl & ~fclr);
      m_sda_sh = {m_sda_sh[0], ext_sda & ~m_oe};
      m_scl_sh = {m_scl_sh[0], ext_scl};
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2", "sda_oe", sda_oe, m_oe);
      chk("R3", "busy", busy, (m_ph == 1) || (m_ph == 2));
      chk("R9", "cmd", cmd_q, m_cmd);
      chk("R8", "buf", buf_q, m_buf);
      chk("R2", "start_det", sdet, m_fl[0]);
      chk("R3", "done", done, m_fl[1]);
      chk("R6", "bus_coll", bcol, m_fl[2]);
      chk("R8", "wr_coll", wcol, m_fl[3]);
    end
  end

  task automatic summary();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !finished) begin
      mismatched++;
      $display("FAIL R1 watchdog: cycles %0d expected below %0d", cycles, WD_LIMIT);
      summary();
    end
  end

  task automatic ncyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cmd_wr = 0; buf_wr = 0; fclr = 0; ext_sda = 1; ext_scl = 1;
    ncyc(3);
    rst_n = 1;
    ncyc(3);
  endtask

  // drives request at a negedge, returns at the negedge after the acting edge
  task automatic request(input logic [4:0] v);
    cmd = v; cmd_wr = 1;
    ncyc(1);
    cmd_wr = 0;
  endtask

  initial begin
    // R1 reset state
    do_reset();
    chk("R1", "oe", sda_oe, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "cmd", cmd_q, 0);
    chk("R1", "buf", buf_q, 0);
    chk("R1", "flags", {wcol, bcol, done, sdet}, 0);

    // R2/R3 normal start, reload 3; R8/R9 locks during sequence
    rel = 7'd3;
    request(5'b00001);
    chk("R2", "busy after request", busy, 1);
    buf_data = 8'hA5; buf_wr = 1;
    cmd = 5'b11110; cmd_wr = 1;
    ncyc(1);
    buf_wr = 0; cmd_wr = 0;
    chk("R8", "wr_coll", wcol, 1);
    chk("R8", "buf unchanged", buf_q, 0);
    chk("R9", "cmd unchanged", cmd_q, 5'b00001);
    ncyc(2);
    chk("R2", "oe before timeout", sda_oe, 0);
    ncyc(1);
    chk("R2", "oe after timeout", sda_oe, 1);
    chk("R2", "start_det", sdet, 1);
    ncyc(3);
    chk("R3", "still busy", busy, 1);
    chk("R3", "done early", done, 0);
    ncyc(1);
    chk("R3", "done", done, 1);
    chk("R3", "busy dropped", busy, 0);
    chk("R3", "sen cleared", cmd_q[0], 0);
    chk("R3", "sda held", sda_oe, 1);
    // R10 clear all; R8 idle write
    fclr = 4'hF; buf_data = 8'h3C; buf_wr = 1;
    ncyc(1);
    fclr = 0; buf_wr = 0;
    chk("R10", "flags cleared", {wcol, bcol, done, sdet}, 0);
    chk("R8", "buf loaded", buf_q, 8'h3C);

    // reload 0: one-cycle periods
    do_reset();
    rel = 7'd0;
    request(5'b00001);
    chk("R2", "oe rel0 first", sda_oe, 0);
    ncyc(1);
    chk("R2", "oe rel0", sda_oe, 1);
    ncyc(1);
    chk("R3", "done rel0", done, 1);

    // R5 request with SCL low
    do_reset();
    rel = 7'd4;
    ext_scl = 0;
    ncyc(3);
    request(5'b00001);
    chk("R5", "bcol scl low", bcol, 1);
    chk("R5", "sen cleared", cmd_q[0], 0);
    chk("R5", "not busy", busy, 0);
    ext_scl = 1;
    ncyc(3);

    // R5 both lines low
    do_reset();
    ext_scl = 0; ext_sda = 0;
    ncyc(3);
    request(5'b00101);
    chk("R5", "bcol both low", bcol, 1);
    chk("R5", "cmd upper kept", cmd_q, 5'b00100);
    chk("R5", "oe released", sda_oe, 0);
    ext_scl = 1; ext_sda = 1;
    ncyc(3);

    // R4/R6 SCL drop mid first period, sync lag
    do_reset();
    rel = 7'd20;
    request(5'b00001);
    ncyc(2);
    ext_scl = 0;
    ncyc(2);
    chk("R4", "no coll before sync", bcol, 0);
    ncyc(1);
    chk("R4", "coll after sync", bcol, 1);
    chk("R6", "abort busy", busy, 0);
    chk("R6", "abort oe", sda_oe, 0);
    ext_scl = 1;
    ncyc(3);

    // R6 SDA low at first timeout
    do_reset();
    rel = 7'd5;
    request(5'b00001);
    ncyc(1);
    ext_sda = 0;
    ncyc(8);
    chk("R6", "bcol sda low", bcol, 1);
    chk("R6", "no start_det", sdet, 0);
    chk("R6", "oe released", sda_oe, 0);
    ext_sda = 1;
    ncyc(3);

    // R7 SCL low in second period ignored
    do_reset();
    rel = 7'd4;
    request(5'b00001);
    ncyc(5);
    chk("R7", "low phase", sda_oe, 1);
    ext_scl = 0;
    ncyc(3);
    ext_scl = 1;
    ncyc(2);
    chk("R7", "done", done, 1);
    chk("R7", "no coll", bcol, 0);

    // R10 set beats clear
    do_reset();
    rel = 7'd10;
    request(5'b00001);
    buf_wr = 1; buf_data = 8'h11; fclr = 4'b1000;
    ncyc(1);
    buf_wr = 0; fclr = 0;
    chk("R10", "set wins", wcol, 1);
    ncyc(2);
    chk("R10", "sticky", wcol, 1);
    fclr = 4'b1000;
    ncyc(1);
    fclr = 0;
    chk("R10", "cleared", wcol, 0);
    ncyc(30);

    // maximum reload, then self-collision from parked state
    do_reset();
    rel = 7'd127;
    request(5'b00001);
    ncyc(260);
    chk("R3", "done max", done, 1);
    chk("R3", "oe max", sda_oe, 1);
    request(5'b00001);
    chk("R5", "self coll", bcol, 1);
    chk("R5", "released", sda_oe, 0);
    ncyc(4);

    summary();
  end
endmodule